// File: doc/BRIEF.md
# Four-Level Address Translation Walker

This block turns a 64-bit virtual address into a 52-bit physical address by reading one 8-byte entry from each of four levels of in-memory translation tables. A request carries the address, a write flag and a user flag. The walk starts at the table whose 4 KB-aligned physical base sits in `root_base`. Each entry it reads gives the frame of the next table. At the last level the entry gives the frame of the final 4 KB page. The walker holds one request at a time. It issues one entry read per level and finishes with a one-cycle `done` pulse. With the pulse come the physical address, a fault code, the level at which the walk stopped, and two flags that tell a separate updater whether the leaf entry's accessed or dirty bit still has to be set.

The request port, the memory request port and the memory response port all use valid/ready. A source that has raised valid keeps it and its payload steady until the cycle in which ready is high. `req_ready` is high only while the walker is idle and is not pulsing `done`. `mem_req_valid` stays high with a steady address until the memory raises `mem_req_ready`. `mem_rsp_ready` is high only while one read is outstanding, so the memory can hold a response back for any number of cycles. Translation runs only when bits 31 and 5 of `ctl_word` are both set. In every other case the walker returns the address unchanged.

Top module: `pgw_walker`

## Requirements
- R1: If `ctl_word` bit 31 or bit 5 is clear, an accepted request completes with `done` one cycle after acceptance. It returns `rsp_paddr` = `req_vaddr[51:0]` and fault 0, and makes no memory read.
- R2: With translation on, an address whose bits 63:48 do not all equal bit 47 completes one cycle after acceptance with fault 1 (non-canonical) and level 0, and makes no memory read. An address with bit 47 set and bits 63:48 all ones is accepted and walked.
- R3: The read at level L (0 = top) goes to {base, idx, 3'b000}. Here idx = vaddr[47-9L : 39-9L]. The level-0 base is `root_base[51:12]`.
- R4: Each entry's frame field, bits 51:12, becomes the base of the next level. A successful walk makes exactly four reads and returns fault 0, level 3, and `rsp_paddr` = {leaf bits 51:12, vaddr[11:0]}.
- R5: An entry with bit 0 (present) clear ends the walk with fault 2 at that level. No further read follows.
- R6: A write request faults with code 3 (write-protect) at the first level where the AND of entry bit 1 over all levels read so far is 0.
- R7: A user request faults with code 4 (privilege) at the first level where the AND of entry bit 2 over all levels read so far is 0. At one level the order of precedence is not-present, then privilege, then write-protect.
- R8: On success, `rsp_need_acc` is the inverse of leaf bit 5, and `rsp_need_dirty` is set for a write whose leaf bit 6 is clear. Both flags are 0 on any fault and on bypass.
- R9: `mem_req_valid` holds with a steady `mem_req_addr` until `mem_req_ready`. At most one read is outstanding.
- R10: `done` is a single-cycle pulse. `req_ready` is low from acceptance until the cycle after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_word | input | 32 | Control word; bit 31 enables paging, bit 5 enables the 64-bit table format |
| root_base | input | 52 | Physical base of the top-level table (4 KB aligned) |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker can accept a request |
| req_vaddr | input | 64 | Virtual address |
| req_write | input | 1 | 1 = write access |
| req_user | input | 1 | 1 = user-level access |
| mem_req_valid | output | 1 | Entry read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 52 | Physical address of the entry |
| mem_rsp_valid | input | 1 | Entry data valid |
| mem_rsp_ready | output | 1 | Walker accepts entry data |
| mem_rsp_data | input | 64 | Entry contents |
| done | output | 1 | One-cycle completion pulse |
| rsp_paddr | output | 52 | Translated physical address |
| rsp_fault | output | 3 | 0 none, 1 non-canonical, 2 not-present, 3 write-protect, 4 privilege |
| rsp_level | output | 2 | Level at which the walk ended |
| rsp_need_acc | output | 1 | Leaf accessed bit was clear |
| rsp_need_dirty | output | 1 | Write to a leaf whose dirty bit was clear |

## Verification
Two situations are hard to reach from the ports. The first is a permission fault that appears only at a deep level, because it depends on bits that accumulate across the earlier entries. The second is the precedence between faults that arise in the same entry. The bench builds a fresh four-entry chain for each request, with per-level masks for the present, write and user bits, so a fault can be placed at any chosen level. Directed cases combine several fault causes in one entry. Memory ready and response timing are random, so the walker waits in both handshake states.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  typedef enum logic [2:0] {
    F_NONE     = 3'd0,
    F_NONCANON = 3'd1,
    F_NOTPRES  = 3'd2,
    F_WRPROT   = 3'd3,
    F_PRIV     = 3'd4
  } fault_e;

  localparam int unsigned EB_PRESENT = 0;
  localparam int unsigned EB_WRITE   = 1;
  localparam int unsigned EB_USER    = 2;
  localparam int unsigned EB_ACC     = 5;
  localparam int unsigned EB_DIRTY   = 6;
endpackage

// File: rtl/pgw_canon.sv
module pgw_canon #(
  parameter int unsigned VA_W = 48
) (
  input  logic [63:0] vaddr,
  output logic        ok
);
  localparam int unsigned EXT_W = 64 - VA_W + 1;
  logic [EXT_W-1:0] ext;
  assign ext = vaddr[63:VA_W-1];
  assign ok  = (&ext) | ~(|ext);
endmodule

// File: rtl/pgw_entry_addr.sv
module pgw_entry_addr #(
  parameter int unsigned PA_W   = 52,
  parameter int unsigned OFF_W  = 12,
  parameter int unsigned IDX_W  = 9,
  parameter int unsigned LEVELS = 4
) (
  input  logic [PA_W-OFF_W-1:0]     base,
  input  logic [63:0]               vaddr,
  input  logic [$clog2(LEVELS)-1:0] lvl,
  output logic [PA_W-1:0]           addr
);
  localparam int unsigned SLOT_W = OFF_W - IDX_W;
  logic [IDX_W-1:0] idx_arr [LEVELS];

  for (genvar g = 0; g < LEVELS; g++) begin : g_idx
    assign idx_arr[g] = vaddr[OFF_W + IDX_W*(LEVELS-1-g) +: IDX_W];
  end

  assign addr = {base, idx_arr[lvl], {SLOT_W{1'b0}}};
endmodule

// File: rtl/pgw_perm.sv
module pgw_perm (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic upd,
  input  logic w_bit,
  input  logic u_bit,
  output logic w_now,
  output logic u_now
);
  logic w_acc, u_acc;

  assign w_now = w_acc & w_bit;
  assign u_now = u_acc & u_bit;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      w_acc <= 1'b1;
      u_acc <= 1'b1;
    end else if (upd) begin
      w_acc <= w_now;
      u_acc <= u_now;
    end
  end

  p_perm_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !w_acc) |=> !w_acc);
  p_user_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !u_acc) |=> !u_acc);
endmodule

// File: rtl/pgw_walker.sv
module pgw_walker #(
  parameter int unsigned VA_W        = 48,
  parameter int unsigned PA_W        = 52,
  parameter int unsigned OFF_W       = 12,
  parameter int unsigned IDX_W       = 9,
  parameter int unsigned LEVELS      = 4,
  parameter int unsigned CTL_PG_BIT  = 31,
  parameter int unsigned CTL_EXT_BIT = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       ctl_word,
  input  logic [PA_W-1:0]   root_base,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [63:0]       req_vaddr,
  input  logic              req_write,
  input  logic              req_user,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [PA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [63:0]       mem_rsp_data,
  output logic              done,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic [2:0]        rsp_fault,
  output logic [$clog2(LEVELS)-1:0] rsp_level,
  output logic              rsp_need_acc,
  output logic              rsp_need_dirty
);
  import pgw_pkg::*;

  localparam int unsigned PFN_W = PA_W - OFF_W;
  localparam int unsigned LVL_W = $clog2(LEVELS);
  localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_RSP} state_e;

  state_e           state;
  logic [63:0]      va_q;
  logic             wr_q, us_q;
  logic [LVL_W-1:0] lvl_q;
  logic [PFN_W-1:0] base_q;
  logic             canon_ok, xlate_on, accept, rsp_fire;
  logic             w_now, u_now;
  logic [PFN_W-1:0] ent_pfn;

  assign xlate_on      = ctl_word[CTL_PG_BIT] & ctl_word[CTL_EXT_BIT];
  assign req_ready     = (state == S_IDLE) && !done;
  assign accept        = req_valid && req_ready;
  assign mem_req_valid = (state == S_REQ);
  assign mem_rsp_ready = (state == S_RSP);
  assign rsp_fire      = mem_rsp_valid && mem_rsp_ready;
  assign ent_pfn       = mem_rsp_data[PA_W-1:OFF_W];

  pgw_canon #(.VA_W(VA_W)) u_canon (
    .vaddr (req_vaddr),
    .ok    (canon_ok)
  );

  pgw_entry_addr #(
    .PA_W(PA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .LEVELS(LEVELS)
  ) u_eaddr (
    .base  (base_q),
    .vaddr (va_q),
    .lvl   (lvl_q),
    .addr  (mem_req_addr)
  );

  pgw_perm u_perm (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (accept),
    .upd   (rsp_fire),
    .w_bit (mem_rsp_data[EB_WRITE]),
    .u_bit (mem_rsp_data[EB_USER]),
    .w_now (w_now),
    .u_now (u_now)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state          <= S_IDLE;
      va_q           <= '0;
      wr_q           <= 1'b0;
      us_q           <= 1'b0;
      lvl_q          <= '0;
      base_q         <= '0;
      done           <= 1'b0;
      rsp_paddr      <= '0;
      rsp_fault      <= F_NONE;
      rsp_level      <= '0;
      rsp_need_acc   <= 1'b0;
      rsp_need_dirty <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        S_IDLE: if (accept) begin
          va_q           <= req_vaddr;
          wr_q           <= req_write;
          us_q           <= req_user;
          lvl_q          <= '0;
          base_q         <= root_base[PA_W-1:OFF_W];
          rsp_need_acc   <= 1'b0;
          rsp_need_dirty <= 1'b0;
          rsp_level      <= '0;
          if (!xlate_on) begin
            done      <= 1'b1;
            rsp_fault <= F_NONE;
            rsp_paddr <= req_vaddr[PA_W-1:0];
          end else if (!canon_ok) begin
            done      <= 1'b1;
            rsp_fault <= F_NONCANON;
            rsp_paddr <= '0;
          end else begin
            state <= S_REQ;
          end
        end
        S_REQ: if (mem_req_ready) state <= S_RSP;
        S_RSP: if (mem_rsp_valid) begin
          rsp_level <= lvl_q;
          if (!mem_rsp_data[EB_PRESENT]) begin
            done <= 1'b1; rsp_fault <= F_NOTPRES; state <= S_IDLE;
          end else if (us_q && !u_now) begin
            done <= 1'b1; rsp_fault <= F_PRIV; state <= S_IDLE;
          end else if (wr_q && !w_now) begin
            done <= 1'b1; rsp_fault <= F_WRPROT; state <= S_IDLE;
          end else if (lvl_q == LAST_LVL) begin
            done           <= 1'b1;
            rsp_fault      <= F_NONE;
            rsp_paddr      <= {ent_pfn, va_q[OFF_W-1:0]};
            rsp_need_acc   <= !mem_rsp_data[EB_ACC];
            rsp_need_dirty <= wr_q && !mem_rsp_data[EB_DIRTY];
            state          <= S_IDLE;
          end else begin
            lvl_q  <= lvl_q + 1'b1;
            base_q <= ent_pfn;
            state  <= S_REQ;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
  p_noncanon_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && xlate_on && !canon_ok) |=> (done && rsp_fault == F_NONCANON && !mem_req_valid));
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_fault_noflags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rsp_fault != F_NONE) |-> (!rsp_need_acc && !rsp_need_dirty));
  p_one_outstanding_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req_valid && mem_rsp_ready));
endmodule

// File: tb/pgw_walker_tb.sv
module pgw_walker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ctl_word = '0;
  logic [51:0] root_base = '0;
  logic        req_valid = 1'b0, req_ready;
  logic [63:0] req_vaddr = '0;
  logic        req_write = 1'b0, req_user = 1'b0;
  logic        mem_req_valid, mem_req_ready = 1'b0;
  logic [51:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0, mem_rsp_ready;
  logic [63:0] mem_rsp_data = '0;
  logic        done;
  logic [51:0] rsp_paddr;
  logic [2:0]  rsp_fault;
  logic [1:0]  rsp_level;
  logic        rsp_need_acc, rsp_need_dirty;

  always #5 clk = ~clk;

  pgw_walker u_dut (.*);

  int checks = 0, failures = 0;
  logic [63:0] tbl [logic [51:0]];
  logic [51:0] e_addr [4];
  logic [2:0]  e_fault;
  int          e_lvl, e_nrd;
  logic [51:0] e_pa;
  logic        e_acc, e_dirty;
  int          rd_cnt, addr_err;

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected result from the requirements
  task automatic model(input logic [63:0] va, input logic wr, input logic us,
                       input logic [31:0] ctl, input logic [51:0] root);
    logic [39:0] base;
    logic [63:0] d;
    logic w, u;
    logic [8:0] idx;
    e_nrd = 0; e_acc = 0; e_dirty = 0; e_pa = '0; e_lvl = 0; e_fault = 3'd0;
    if (!(ctl[31] && ctl[5])) begin e_pa = va[51:0]; return; end
    if (!(va[63:47] == '0 || va[63:47] == '1)) begin e_fault = 3'd1; return; end
    base = root[51:12]; w = 1; u = 1; d = '0;
    for (int l = 0; l < 4; l++) begin
      idx = va[47-9*l -: 9];
      e_addr[l] = {base, idx, 3'b000};
      e_nrd++;
      d = tbl.exists(e_addr[l]) ? tbl[e_addr[l]] : 64'h0;
      e_lvl = l;
      if (!d[0]) begin e_fault = 3'd2; return; end
      w &= d[1]; u &= d[2];
      if (us && !u) begin e_fault = 3'd4; return; end
      if (wr && !w) begin e_fault = 3'd3; return; end
      base = d[51:12];
    end
    e_pa = {base, va[11:0]};
    e_acc = !d[5];
    e_dirty = wr && !d[6];
  endtask

  task automatic build(input logic [63:0] va, input logic [51:0] root,
                       input logic [3:0] pm, input logic [3:0] wm, input logic [3:0] um,
                       input logic [3:0] am, input logic [3:0] dm);
    logic [39:0] base, nxt;
    logic [11:0] low;
    logic [51:0] a;
    tbl.delete();
    base = root[51:12];
    for (int l = 0; l < 4; l++) begin
      a = {base, va[47-9*l -: 9], 3'b000};
      nxt = {$urandom, $urandom};
      low = 12'($urandom);
      low[0] = pm[l]; low[1] = wm[l]; low[2] = um[l]; low[5] = am[l]; low[6] = dm[l];
      tbl[a] = {12'($urandom), nxt, low};
      base = nxt;
    end
  endtask

  // memory responder: decisions at the falling edge
  initial begin
    logic busy = 0, req_fire = 0, rsp_fire = 0;
    logic [63:0] dat = '0;
    forever begin
      @(negedge clk);
      if (req_fire) begin
        if (rd_cnt < 4 && mem_req_addr != e_addr[rd_cnt]) addr_err++;
        dat = tbl.exists(mem_req_addr) ? tbl[mem_req_addr] : 64'h0;
        rd_cnt++;
        busy = 1;
      end
      if (rsp_fire) mem_rsp_valid = 0;
      mem_req_ready = ($urandom % 3) != 0;
      if (busy && !mem_rsp_valid && ($urandom % 2) == 0) begin
        mem_rsp_valid = 1; mem_rsp_data = dat; busy = 0;
      end
      req_fire = mem_req_valid && mem_req_ready;
      rsp_fire = mem_rsp_valid && mem_rsp_ready;
    end
  end

  task automatic run(input logic [63:0] va, input logic wr, input logic us, input logic [31:0] ctl);
    int cyc;
    string tg;
    model(va, wr, us, ctl, root_base);
    rd_cnt = 0; addr_err = 0;
    @(negedge clk);
    ctl_word = ctl; req_vaddr = va; req_write = wr; req_user = us; req_valid = 1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    if (e_nrd > 0) chk(!req_ready, "R10 busy", 64'(req_ready), 0);
    cyc = 0;
    while (!done && cyc < 2000) begin @(negedge clk); cyc++; end
    case (e_fault)
      3'd1: tg = "R2"; 3'd2: tg = "R5"; 3'd3: tg = "R6"; 3'd4: tg = "R7";
      default: tg = (e_nrd == 0) ? "R1" : "R4";
    endcase
    chk(done, {tg, " done"}, 64'(done), 1);
    chk(rsp_fault == e_fault, {tg, " fault"}, 64'(rsp_fault), 64'(e_fault));
    if (e_fault != 3'd0 || e_nrd > 0)
      chk(rsp_level == 2'(e_lvl), {tg, " level"}, 64'(rsp_level), 64'(e_lvl));
    if (e_fault == 3'd0)
      chk(rsp_paddr == e_pa, {tg, " paddr"}, 64'(rsp_paddr), 64'(e_pa));
    chk({rsp_need_acc, rsp_need_dirty} == {e_acc, e_dirty}, "R8 acc/dirty",
        64'({rsp_need_acc, rsp_need_dirty}), 64'({e_acc, e_dirty}));
    chk(rd_cnt == e_nrd, "R3 read count", 64'(rd_cnt), 64'(e_nrd));
    chk(addr_err == 0, "R3 entry address R9", 64'(addr_err), 0);
    @(negedge clk);
    chk(!done, "R10 pulse", 64'(done), 0);
  endtask

  localparam logic [31:0] CTL_ON = 32'h8000_0020;

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R10 actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [63:0] va;
    logic [31:0] ctl;
    void'($urandom(32'h5eed));
    root_base = {40'h12_3456_789a, 12'h000};
    repeat (3) @(negedge clk);
    chk(!done && req_ready && !mem_req_valid, "R10 reset", 64'({done, req_ready, mem_req_valid}), 64'b010);
    rst_n = 1;
    // R1 bypass: paging bit clear, then extension bit clear
    run(64'hdead_beef_0123_4567, 1, 1, 32'h0000_0020);
    run(64'h1234_5678_9abc_def0, 0, 0, 32'h8000_0000);
    // R2 non-canonical
    run(64'h0001_0000_0000_1000, 0, 0, CTL_ON);
    run(64'hfffe_8000_0000_0000, 0, 0, CTL_ON);
    // R4/R8 kernel-half address, full walk, write with A and D clear
    va = 64'hffff_8765_4321_0abc;
    build(va, root_base, 4'hf, 4'hf, 4'hf, 4'h0, 4'h0);
    run(va, 1, 0, CTL_ON);
    // R8 read with A set: no flags
    build(va, root_base, 4'hf, 4'hf, 4'hf, 4'hf, 4'h0);
    run(va, 0, 0, CTL_ON);
    // R5 not present at level 0 and level 2
    va = 64'h0000_1234_5678_9000;
    build(va, root_base, 4'b1110, 4'hf, 4'hf, 4'h0, 4'h0);
    run(va, 0, 0, CTL_ON);
    build(va, root_base, 4'b1011, 4'hf, 4'hf, 4'h0, 4'h0);
    run(va, 0, 0, CTL_ON);
    // R6 read-only at level 1, write faults; read passes
    build(va, root_base, 4'hf, 4'b1101, 4'hf, 4'h0, 4'h0);
    run(va, 1, 0, CTL_ON);
    run(va, 0, 0, CTL_ON);
    // R7 supervisor-only leaf that is also read-only: privilege wins
    build(va, root_base, 4'hf, 4'b0111, 4'b0111, 4'h0, 4'h0);
    run(va, 1, 1, CTL_ON);
    // R7 not-present wins over both permission causes
    build(va, root_base, 4'b1110, 4'b1110, 4'b1110, 4'h0, 4'h0);
    run(va, 1, 1, CTL_ON);
    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [3:0] pm, wm, um;
      va = {$urandom, $urandom};
      if (($urandom % 10) != 0) va[63:48] = {16{va[47]}};
      ctl = (($urandom % 8) == 0) ? $urandom : CTL_ON;
      for (int l = 0; l < 4; l++) begin
        pm[l] = ($urandom % 10) != 0;
        wm[l] = ($urandom % 8) != 0;
        um[l] = ($urandom % 8) != 0;
      end
      build(va, root_base, pm, wm, um, 4'($urandom), 4'($urandom));
      run(va, 1'($urandom), 1'($urandom), ctl);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule